// File: doc/BRIEF.md
# Mixed-Rate TDM Memory Address Sequencer

This block drives the address side of an external byte-wide buffer memory in a bridge between serial TDM links and a parallel memory port. It serves sixteen low-rate links at 2.048 Mb/s and eight high-rate links at 8.192 Mb/s. Time is counted in high-rate channel periods of 32 parallel-clock cycles. Each period opens with a group of twelve write accesses, which place received serial bytes into receive regions. A four-cycle gap follows. Then comes a group of twelve read accesses, which fetch bytes to transmit. Each group has eight high-rate slots and one quartet of low-rate links, and the quartet moves on by four links from one period to the next.

A frame pulse aligns the sequencer to channel 0 and quartet a, and it swaps the active half of the double-buffered 13-bit memory map. Each access carries a direction flag, the serial stream number and the channel number that the byte belongs to. The read side runs ahead of the write side, by two channels for low-rate links and by eight channels for high-rate links, and it wraps modulo the frame.

Top module: `mrs_addr_seq`

## Requirements
- R1: After reset, and until the first frame pulse is sampled, every output is 0 (`acc_vld_o`=0, address 0).
- R2: In each 32-cycle period, cycles 0–11 carry write accesses (`acc_vld_o`=1, `acc_wr_o`=1), cycles 16–27 carry read accesses (`acc_vld_o`=1, `acc_wr_o`=0), and the remaining cycles are idle. In an idle cycle `acc_vld_o`, `acc_wr_o`, `mem_addr_o`, `strm_o` and `chan_o` are all 0.
- R3: Inside a group, slots 0–7 serve high-rate streams 16 to 23 in rising order. Slots 8–11 serve the four low-rate streams of the current quartet in rising order.
- R4: The quartet index is the high-rate channel number modulo 4. Index 0 (a) serves streams 0–3, 1 (b) streams 4–7, 2 (c) streams 8–11 and 3 (d) streams 12–15.
- R5: `chan_o` gives the channel of the access. A high-rate write uses channel h, the high-rate channel counter (0–127), and a high-rate read uses (h+8) mod 128. A low-rate write uses channel l = h/4 (0–31), and a low-rate read uses (l+2) mod 32.
- R6: Address bit 11 is 1 for writes (receive regions) and 0 for reads (transmit regions). Address bit 10 is 1 for high-rate streams and 0 for low-rate streams. Low-rate accesses keep bit 9 at 0.
- R7: The offset within a region, in bits 9:0, is channel×8 + (stream−16) for high-rate accesses and channel×16 + stream for low-rate accesses.
- R8: Address bit 12 equals the frame parity XOR `bank_pol_i`, where `bank_pol_i` is sampled in the cycle before the output. The frame parity is 0 after reset and toggles at every sampled frame pulse.
- R9: A frame pulse sampled at any point, including in mid-period, makes the next output write slot 0: stream 16, channel 0, quartet a. Without frame pulses the high-rate channel counter wraps from 127 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, sampled on the rising clock edge |
| bank_pol_i | input | 1 | Buffer-half polarity, XORed with the frame parity to form address bit 12 |
| mem_addr_o | output | 13 | External memory address |
| acc_vld_o | output | 1 | An access is issued in this cycle |
| acc_wr_o | output | 1 | 1 = write (receive region), 0 = read (transmit region) |
| strm_o | output | 5 | Serial stream number, 0–23 |
| chan_o | output | 7 | Channel number of the access |

## Verification
The bench aims at the two read-ahead wraps. A high-rate read late in the frame must land on channel (h+8) mod 128, and a low-rate read must land on (l+2) mod 32. A design that dropped the modulo or added the wrong offset would show a channel or address outside that range at the end of the frame. The bench also fires frame pulses in mid-period, and twice in a row, to catch a sequencer that keeps its old slot phase or quartet, or that fails to toggle the buffer half on each pulse. Finally it checks that nothing is issued before the first pulse and that `bank_pol_i` reaches address bit 12 with exactly one cycle of latency.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int STRM_W = 5;

  typedef enum logic [1:0] {
    PH_WRITE = 2'd0,
    PH_GAP   = 2'd1,
    PH_READ  = 2'd2,
    PH_REST  = 2'd3
  } phase_e;
endpackage

// File: rtl/mrs_timebase.sv
module mrs_timebase #(
  parameter int PERIOD_CYC = 32,
  parameter int N_HCH      = 128,
  localparam int CYC_W     = $clog2(PERIOD_CYC),
  localparam int HCH_W     = $clog2(N_HCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_i,
  output logic [CYC_W-1:0] cyc_n,
  output logic [HCH_W-1:0] hch_n,
  output logic             par_n,
  output logic             arm_n
);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(PERIOD_CYC - 1);
  localparam logic [HCH_W-1:0] HCH_LAST = HCH_W'(N_HCH - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [HCH_W-1:0] hch_q;
  logic             par_q;
  logic             arm_q;

  // next-state: a frame pulse realigns everything, else count cycles, then channels
  always_comb begin
    cyc_n = cyc_q;
    hch_n = hch_q;
    par_n = par_q;
    arm_n = arm_q | fp_i;
    if (fp_i) begin
      cyc_n = '0;
      hch_n = '0;
      par_n = ~par_q;
    end else if (cyc_q == CYC_LAST) begin
      cyc_n = '0;
      hch_n = (hch_q == HCH_LAST) ? '0 : hch_q + HCH_W'(1);
    end else begin
      cyc_n = cyc_q + CYC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      hch_q <= '0;
      par_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      cyc_q <= cyc_n;
      hch_q <= hch_n;
      par_q <= par_n;
      arm_q <= arm_n;
    end
  end
endmodule

// File: rtl/mrs_slot_dec.sv
module mrs_slot_dec
  import mrs_pkg::*;
#(
  parameter int PERIOD_CYC = 32,
  parameter int N_HI       = 8,
  parameter int N_LO_GRP   = 4,
  parameter int LO_DIV     = 4,
  parameter int GAP        = 4,
  localparam int CYC_W     = $clog2(PERIOD_CYC),
  localparam int QW        = $clog2(LO_DIV)
) (
  input  logic [CYC_W-1:0]  cyc,
  input  logic [QW-1:0]     quad,
  output phase_e            phase,
  output logic              hi,
  output logic [STRM_W-1:0] strm
);
  localparam int GRP      = N_HI + N_LO_GRP;
  localparam int RD0      = GRP + GAP;
  localparam int RD_END   = RD0 + GRP;
  localparam int N_LO_TOT = N_LO_GRP * LO_DIV;

  localparam logic [CYC_W-1:0] C_GRP    = CYC_W'(GRP);
  localparam logic [CYC_W-1:0] C_RD0    = CYC_W'(RD0);
  localparam logic [CYC_W-1:0] C_RD_END = CYC_W'(RD_END);
  localparam logic [CYC_W-1:0] C_NHI    = CYC_W'(N_HI);

  logic [CYC_W-1:0] slot;
  logic             busy;

  // position inside the period -> phase and slot index
  always_comb begin
    phase = PH_REST;
    slot  = '0;
    if (cyc < C_GRP) begin
      phase = PH_WRITE;
      slot  = cyc;
    end else if (cyc < C_RD0) begin
      phase = PH_GAP;
    end else if (cyc < C_RD_END) begin
      phase = PH_READ;
      slot  = cyc - C_RD0;
    end
  end

  assign busy = (phase == PH_WRITE) || (phase == PH_READ);

  // slot index -> stream: fixed high-rate slots first, then the rotating quartet
  always_comb begin
    hi   = busy && (slot < C_NHI);
    strm = '0;
    if (hi) begin
      strm = STRM_W'(N_LO_TOT) + STRM_W'(slot);
    end else if (busy) begin
      strm = STRM_W'(quad) * STRM_W'(N_LO_GRP) + STRM_W'(slot - C_NHI);
    end
  end
endmodule

// File: rtl/mrs_addr_gen.sv
module mrs_addr_gen #(
  parameter int N_HCH      = 128,
  parameter int N_HI       = 8,
  parameter int N_LO_TOT   = 16,
  parameter int LO_DIV     = 4,
  parameter int RD_OFS_HI  = 8,
  parameter int RD_OFS_LO  = 2,
  localparam int HCH_W     = $clog2(N_HCH),
  localparam int QW        = $clog2(LO_DIV),
  localparam int LCH_W     = HCH_W - QW,
  localparam int HSEL_W    = $clog2(N_HI),
  localparam int LSEL_W    = $clog2(N_LO_TOT),
  localparam int HI_OFF_W  = HCH_W + HSEL_W,
  localparam int LO_OFF_W  = LCH_W + LSEL_W,
  localparam int AW        = HI_OFF_W + 3
) (
  input  logic [HCH_W-1:0]  hch,
  input  logic              wr,
  input  logic              hi,
  input  logic [LSEL_W-1:0] sel,
  input  logic              bank,
  output logic [AW-1:0]     addr,
  output logic [HCH_W-1:0]  chan
);
  logic [HCH_W-1:0]    hch_rd;
  logic [LCH_W-1:0]    lch;
  logic [LCH_W-1:0]    lch_rd;
  logic [HCH_W-1:0]    ch_hi;
  logic [LCH_W-1:0]    ch_lo;
  logic [HI_OFF_W-1:0] off;

  // read-ahead wraps by truncation: channel counts are powers of two
  assign hch_rd = hch + HCH_W'(RD_OFS_HI);
  assign lch    = hch[HCH_W-1:QW];
  assign lch_rd = lch + LCH_W'(RD_OFS_LO);
  assign ch_hi  = wr ? hch : hch_rd;
  assign ch_lo  = wr ? lch : lch_rd;

  always_comb begin
    if (hi) begin
      off  = {ch_hi, sel[HSEL_W-1:0]};
      chan = ch_hi;
    end else begin
      off  = HI_OFF_W'({ch_lo, sel});
      chan = HCH_W'(ch_lo);
    end
  end

  // bank | receive/transmit | rate | offset
  assign addr = {bank, wr, hi, off};

  if (LO_OFF_W > HI_OFF_W) begin : g_bad_width
    $error("low-rate region offset wider than high-rate region");
  end
endmodule

// File: rtl/mrs_addr_seq.sv
module mrs_addr_seq
  import mrs_pkg::*;
#(
  parameter int PERIOD_CYC = 32,
  parameter int N_HI       = 8,
  parameter int N_LO_GRP   = 4,
  parameter int LO_DIV     = 4,
  parameter int GAP        = 4,
  parameter int N_HCH      = 128,
  parameter int RD_OFS_HI  = 8,
  parameter int RD_OFS_LO  = 2,
  localparam int CYC_W     = $clog2(PERIOD_CYC),
  localparam int HCH_W     = $clog2(N_HCH),
  localparam int QW        = $clog2(LO_DIV),
  localparam int N_LO_TOT  = N_LO_GRP * LO_DIV,
  localparam int LSEL_W    = $clog2(N_LO_TOT),
  localparam int AW        = HCH_W + $clog2(N_HI) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_i,
  input  logic              bank_pol_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              acc_vld_o,
  output logic              acc_wr_o,
  output logic [STRM_W-1:0] strm_o,
  output logic [HCH_W-1:0]  chan_o
);
  logic [CYC_W-1:0]  cyc_n;
  logic [HCH_W-1:0]  hch_n;
  logic              par_n;
  logic              arm_n;
  phase_e            phase;
  logic              hi;
  logic [STRM_W-1:0] strm;
  logic              wr;
  logic              vld;
  logic [AW-1:0]     addr;
  logic [HCH_W-1:0]  chan;

  logic [AW-1:0]     addr_d;
  logic              vld_d;
  logic              wr_d;
  logic [STRM_W-1:0] strm_d;
  logic [HCH_W-1:0]  chan_d;

  mrs_timebase #(
    .PERIOD_CYC (PERIOD_CYC),
    .N_HCH      (N_HCH)
  ) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .fp_i  (fp_i),
    .cyc_n (cyc_n),
    .hch_n (hch_n),
    .par_n (par_n),
    .arm_n (arm_n)
  );

  mrs_slot_dec #(
    .PERIOD_CYC (PERIOD_CYC),
    .N_HI       (N_HI),
    .N_LO_GRP   (N_LO_GRP),
    .LO_DIV     (LO_DIV),
    .GAP        (GAP)
  ) u_dec (
    .cyc   (cyc_n),
    .quad  (hch_n[QW-1:0]),
    .phase (phase),
    .hi    (hi),
    .strm  (strm)
  );

  assign wr  = (phase == PH_WRITE);
  assign vld = arm_n && ((phase == PH_WRITE) || (phase == PH_READ));

  mrs_addr_gen #(
    .N_HCH     (N_HCH),
    .N_HI      (N_HI),
    .N_LO_TOT  (N_LO_TOT),
    .LO_DIV    (LO_DIV),
    .RD_OFS_HI (RD_OFS_HI),
    .RD_OFS_LO (RD_OFS_LO)
  ) u_ag (
    .hch  (hch_n),
    .wr   (wr),
    .hi   (hi),
    .sel  (strm[LSEL_W-1:0]),
    .bank (par_n ^ bank_pol_i),
    .addr (addr),
    .chan (chan)
  );

  // output next-state: idle cycles drive all zeros
  always_comb begin
    vld_d  = vld;
    wr_d   = vld & wr;
    addr_d = vld ? addr : '0;
    strm_d = vld ? strm : '0;
    chan_d = vld ? chan : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr_o <= '0;
      acc_vld_o  <= 1'b0;
      acc_wr_o   <= 1'b0;
      strm_o     <= '0;
      chan_o     <= '0;
    end else begin
      mem_addr_o <= addr_d;
      acc_vld_o  <= vld_d;
      acc_wr_o   <= wr_d;
      strm_o     <= strm_d;
      chan_o     <= chan_d;
    end
  end
endmodule

// File: rtl/mrs_addr_seq_chk.sv
module mrs_addr_seq_chk #(
  parameter int AW   = 13,
  parameter int CH_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fp_i,
  input logic            bank_pol_i,
  input logic [AW-1:0]   mem_addr_o,
  input logic            acc_vld_o,
  input logic            acc_wr_o,
  input logic [4:0]      strm_o,
  input logic [CH_W-1:0] chan_o
);
  logic armed_q;
  logic par_q;
  logic pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      par_q   <= 1'b0;
      pol_q   <= 1'b0;
    end else begin
      armed_q <= armed_q | fp_i;
      par_q   <= par_q ^ fp_i;
      pol_q   <= bank_pol_i;
    end
  end

  AST_QUIET_UNTIL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !acc_vld_o); // R1

  AST_IDLE_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld_o |-> (mem_addr_o == '0 && strm_o == 5'd0 && chan_o == '0 && !acc_wr_o)); // R2

  AST_WRITE_TO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_o && acc_wr_o) |-> mem_addr_o[11]); // R6

  AST_READ_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_o && !acc_wr_o) |-> !mem_addr_o[11]); // R6

  AST_RATE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld_o |-> (mem_addr_o[10] == (strm_o >= 5'd16))); // R6

  AST_QUARTET_FOLLOWS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_o && $past(acc_vld_o) && $past(strm_o) == 5'd23) |->
      (strm_o < 5'd16 && strm_o[1:0] == 2'd0)); // R3

  AST_BANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld_o |-> (mem_addr_o[AW-1] == (par_q ^ pol_q))); // R8

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fp_i |=> (acc_vld_o && acc_wr_o && strm_o == 5'd16 && chan_o == '0)); // R9
endmodule

bind mrs_addr_seq mrs_addr_seq_chk #(.AW(AW), .CH_W(HCH_W)) u_chk (.*);

// File: tb/mrs_addr_seq_bench.sv
module mrs_addr_seq_bench;
  typedef struct {
    int vld;
    int wr;
    int addr;
    int strm;
    int chan;
    int unarmed;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        fp;
  logic        pol;
  logic [12:0] mem_addr;
  logic        acc_vld;
  logic        acc_wr;
  logic [4:0]  strm;
  logic [6:0]  chan;

  exp_t q[$];
  int   n_vec;
  int   n_bad;
  int   m_c, m_h, m_par, m_arm;

  mrs_addr_seq u_mrs_addr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fp_i       (fp),
    .bank_pol_i (pol),
    .mem_addr_o (mem_addr),
    .acc_vld_o  (acc_vld),
    .acc_wr_o   (acc_wr),
    .strm_o     (strm),
    .chan_o     (chan)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected access from the requirements, for the position the model now holds
  function automatic exp_t calc(input int p);
    exp_t e;
    int   s, wr, ch, bank;
    e = '{vld: 0, wr: 0, addr: 0, strm: 0, chan: 0, unarmed: 0};
    if (m_arm == 0) begin
      e.unarmed = 1;
      return e;
    end
    if (m_c < 12) begin
      wr = 1; s = m_c;
    end else if (m_c >= 16 && m_c < 28) begin
      wr = 0; s = m_c - 16;
    end else begin
      return e;
    end
    bank  = m_par ^ p;
    e.vld = 1;
    e.wr  = wr;
    if (s < 8) begin
      e.strm = 16 + s;
      ch     = wr ? m_h : (m_h + 8) % 128;
      e.addr = bank * 4096 + (wr ? 2048 : 0) + 1024 + ch * 8 + s;
    end else begin
      e.strm = (m_h % 4) * 4 + (s - 8);
      ch     = wr ? m_h / 4 : (m_h / 4 + 2) % 32;
      e.addr = bank * 4096 + (wr ? 2048 : 0) + ch * 16 + e.strm;
    end
    e.chan = ch;
    return e;
  endfunction

  // driver: apply inputs for the next edge and queue what that edge must produce
  task automatic drive(input logic f, input logic p);
    fp  = f;
    pol = p;
    if (f) begin
      m_arm = 1; m_c = 0; m_h = 0; m_par ^= 1;
    end else if (m_c == 31) begin
      m_c = 0; m_h = (m_h + 1) % 128;
    end else begin
      m_c++;
    end
    q.push_back(calc(p));
    if (f) begin
      @(posedge clk);
      #2;
      n_vec++;
      if (!(acc_vld && acc_wr && strm == 5'd16 && chan == 7'd0)) begin
        n_bad++;
        $display("FAIL R9 restart: vld=%0d wr=%0d strm=%0d chan=%0d expected 1 1 16 0",
                 acc_vld, acc_wr, strm, chan);
      end
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic p);
    for (int i = 0; i < n; i++) drive(1'b0, p);
  endtask

  // monitor: compare each produced access against the queue front
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      bit   bad;
      e   = q.pop_front();
      bad = 0;
      n_vec++;
      if (e.unarmed != 0 && (acc_vld !== 1'b0 || mem_addr !== 13'd0)) begin
        bad = 1;
        $display("FAIL R1 unarmed: vld=%0d addr=%0h expected 0 0", acc_vld, mem_addr);
      end
      if (int'(acc_vld) != e.vld || int'(acc_wr) != e.wr) begin
        bad = 1;
        $display("FAIL R2 vld/wr: %0d/%0d expected %0d/%0d", acc_vld, acc_wr, e.vld, e.wr);
      end
      if (int'(strm) != e.strm) begin
        bad = 1;
        if (e.strm >= 16)
          $display("FAIL R3 stream: %0d expected %0d", strm, e.strm);
        else
          $display("FAIL R4 quartet stream: %0d expected %0d", strm, e.strm);
      end
      if (int'(chan) != e.chan) begin
        bad = 1;
        $display("FAIL R5 channel: %0d expected %0d", chan, e.chan);
      end
      if (int'(mem_addr[12]) != e.addr / 4096) begin
        bad = 1;
        $display("FAIL R8 bank bit: %0d expected %0d", mem_addr[12], e.addr / 4096);
      end
      if (int'(mem_addr[11:10]) != (e.addr / 1024) % 4) begin
        bad = 1;
        $display("FAIL R6 region: %0h expected %0h", mem_addr[11:10], (e.addr / 1024) % 4);
      end
      if (int'(mem_addr[9:0]) != e.addr % 1024) begin
        bad = 1;
        $display("FAIL R7 offset: %0h expected %0h", mem_addr[9:0], e.addr % 1024);
      end
      if (bad) n_bad++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    m_c = 0; m_h = 0; m_par = 0; m_arm = 0;
    rst_n = 1'b0; fp = 1'b0; pol = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (acc_vld !== 1'b0 || mem_addr !== 13'd0 || strm !== 5'd0 || chan !== 7'd0) begin
      n_bad++;
      $display("FAIL R1 reset: vld=%0d addr=%0h expected 0 0", acc_vld, mem_addr);
    end
    rst_n = 1'b1;
    run(60, 1'b0);            // R1: no accesses before the first frame pulse
    drive(1'b1, 1'b0);        // first frame, parity 1
    run(4096 + 300, 1'b0);    // full frame plus free-running wrap of channels (R5, R9)
    run(13, 1'b0);            // land in mid-period
    drive(1'b1, 1'b1);        // R9 mid-period realign, R8 polarity 1
    run(2100, 1'b1);
    run(150, 1'b0);           // R8 polarity change in mid-frame
    drive(1'b1, 1'b0);        // two pulses back to back: parity toggles twice
    drive(1'b1, 1'b0);
    run(4200, 1'b0);
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule